// File: doc/BRIEF.md
# Signed-Magnitude Accumulator Adder

This block is the add and subtract datapath of a 38-bit accumulator that keeps its value in sign-magnitude form. The word has a sign bit at bit 37, two guard bits above the data magnitude (Q at bit 36 and P at bit 35), and a 35-bit magnitude in bits 34:0. Memory operands are 36 bits wide, with the sign at bit 35 and the magnitude in bits 34:0. The block carries out one operation for each cycle in which `start` is high. It supports add and subtract, add and subtract of the operand's magnitude, load with the operand's sign or with that sign inverted, rounding from the multiplier-quotient register, and an overflow test.

Operands with differing signs are combined by a one's-complement add across the 37-bit field made of Q, P and the magnitude, with an end-around correction. A sticky overflow flag records any change of the P bit that an add-class operation causes. The overflow test returns that flag and clears it in the same operation. All outputs are registered, and `done` pulses in the cycle after `start`.

Top module: `acc_sm_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator, `ovf`, `tov_flag` and `done` all become 0.
- R2: Add (op code 0) with equal signs adds the operand magnitude to the 37-bit field, drops any carry out of the field and keeps the sign. `ovf` becomes 1 when bit 35 (P) of the result differs from P before the operation.
- R3: When the effective operand sign differs from the accumulator sign, the block complements the 37-bit field and adds the magnitude. On a carry out of the field it inverts the sign, adds one and applies the P-change overflow rule. With no carry it complements the sum again, keeps the sign and leaves `ovf` unchanged. A zero result may be negative.
- R4: `ovf` stays 1 through every operation other than the overflow test.
- R5: Subtract (op code 1) inverts the operand sign before adding. Add-magnitude (op code 2) forces the operand positive. Subtract-magnitude (op code 3) forces it negative.
- R6: Load (op code 4) writes the operand sign and magnitude and clears Q and P. Negated load (op code 5) does the same with the sign inverted. Neither changes `ovf`.
- R7: Round (op code 6) adds one to the 37-bit field, keeping the sign, when `mq_hi` is 1. When `mq_hi` is 0 it leaves the accumulator unchanged.
- R8: The overflow test (op code 7) loads the current `ovf` into `tov_flag` and clears `ovf`, leaving the accumulator unchanged. Every other operation writes 0 to `tov_flag`.
- R9: `done` is 1 exactly in the cycle after a cycle with `start` high. Without `start`, the accumulator and `ovf` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Perform the operation selected by `op` |
| op | input | 3 | Operation code (0 to 7, see requirements) |
| operand | input | 36 | Sign-magnitude memory operand, sign at bit 35 |
| mq_hi | input | 1 | Most significant magnitude bit of the multiplier-quotient register |
| acc | output | 38 | Accumulator: sign, Q, P, 35-bit magnitude |
| ovf | output | 1 | Sticky overflow flag |
| tov_flag | output | 1 | Overflow value captured by the last overflow test |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `op`, `operand` and `mq_hi` are sampled only in cycles with `start` high, and that `rst_n` is low at the first clock edges, so no property looks back past reset. The bench meets these assumptions by changing every input on the falling edge and holding `start` high for a single cycle per operation. It sets up each vector with a load followed by an overflow test, so each arithmetic case begins from a known accumulator with Q and P at zero and the overflow flag clear. Cases that need P set beforehand are reached by chaining operations in directed sequences.

// File: rtl/acc_sm_pkg.sv
`timescale 1ns/1ps
// Shared operation codes for the signed-magnitude accumulator datapath.
package acc_sm_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDM = 3'd2,
        OP_SUBM = 3'd3,
        OP_LD   = 3'd4,
        OP_LDN  = 3'd5,
        OP_RND  = 3'd6,
        OP_TOV  = 3'd7
    } acc_op_e;
endpackage

// File: rtl/acc_opnd_cond.sv
`timescale 1ns/1ps
// Operand sign conditioning.
// Works out the effective operand sign for add-class operations and the
// sign written by the load operations. Purely combinational. The codes
// come from acc_sm_pkg.
module acc_opnd_cond
    import acc_sm_pkg::*;
(
    input  acc_op_e op_i,
    input  logic    sign_i,
    output logic    add_sign_o,
    output logic    load_sign_o
);
    // Select the effective sign per operation.
    always_comb begin
        add_sign_o  = sign_i;
        load_sign_o = sign_i;
        case (op_i)
            OP_SUB:  add_sign_o  = ~sign_i;
            OP_ADDM: add_sign_o  = 1'b0;
            OP_SUBM: add_sign_o  = 1'b1;
            OP_LDN:  load_sign_o = ~sign_i;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_mag_addsub.sv
`timescale 1ns/1ps
// Sign-magnitude add of an operand magnitude to the accumulator field.
// The field is MAG_W+2 bits (Q, P, magnitude). Differing signs are
// handled by one's complement with an end-around correction. Assumes the
// operand magnitude is narrower than the field, so it is zero-extended.
module acc_mag_addsub #(
    parameter int MAG_W = 35
) (
    input  logic                 acc_sign_i,
    input  logic [MAG_W+1:0]     acc_field_i,
    input  logic                 op_sign_i,
    input  logic [MAG_W-1:0]     op_mag_i,
    output logic                 res_sign_o,
    output logic [MAG_W+1:0]     res_field_o,
    output logic                 ovf_o
);
    localparam int FIELD_W = MAG_W + 2;
    localparam int P_IDX   = MAG_W;
    localparam logic [FIELD_W-1:0] FIELD_ONE = FIELD_W'(1);

    logic               differ;
    logic [FIELD_W-1:0] pre;
    logic [FIELD_W:0]   sum;
    logic               carry;

    // Complement the field when the signs differ, then add.
    always_comb begin
        differ = acc_sign_i ^ op_sign_i;
        pre    = differ ? ~acc_field_i : acc_field_i;
        sum    = {1'b0, pre} + {3'b000, op_mag_i};
        carry  = sum[FIELD_W];
    end

    // Resolve the result sign, magnitude and P-change overflow.
    always_comb begin
        res_sign_o  = acc_sign_i;
        res_field_o = sum[FIELD_W-1:0];
        ovf_o       = 1'b0;
        if (differ) begin
            if (carry) begin
                res_sign_o  = ~acc_sign_i;
                res_field_o = sum[FIELD_W-1:0] + FIELD_ONE;
                ovf_o       = res_field_o[P_IDX] != acc_field_i[P_IDX];
            end else begin
                res_field_o = ~sum[FIELD_W-1:0];
            end
        end else begin
            ovf_o = res_field_o[P_IDX] != acc_field_i[P_IDX];
        end
    end
endmodule

// File: rtl/acc_ovf_flag.sv
`timescale 1ns/1ps
// Sticky overflow flag. Set by set_i and cleared by clr_i. The two
// requests never arrive together, because they come from different
// operations.
module acc_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (clr_i) flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
    end

    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !clr_i |=> flag_o);
    a_r8_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);
endmodule

// File: rtl/acc_sm_adder.sv
`timescale 1ns/1ps
// Signed-magnitude accumulator adder, top level.
// Holds the accumulator (sign, Q, P, magnitude), performs one operation
// for each cycle with start high, and registers every output. Assumes op,
// operand and mq_hi are valid whenever start is high.
module acc_sm_adder
    import acc_sm_pkg::*;
#(
    parameter int MAG_W = 35
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op,
    input  logic [MAG_W:0]     operand,
    input  logic               mq_hi,
    output logic [MAG_W+2:0]   acc,
    output logic               ovf,
    output logic               tov_flag,
    output logic               done
);
    localparam int FIELD_W = MAG_W + 2;
    localparam int ACC_W   = MAG_W + 3;
    localparam logic [FIELD_W-1:0] FIELD_ONE = FIELD_W'(1);

    acc_op_e            op_e;
    logic               acc_sign;
    logic [FIELD_W-1:0] acc_field;
    logic               add_sign, load_sign;
    logic               res_sign;
    logic [FIELD_W-1:0] res_field;
    logic               res_ovf;
    logic [ACC_W-1:0]   acc_d;
    logic               ovf_set, ovf_clr;
    logic               sum_op;

    // Split the accumulator and decode the operation.
    always_comb begin
        op_e      = acc_op_e'(op);
        acc_sign  = acc[ACC_W-1];
        acc_field = acc[FIELD_W-1:0];
        sum_op    = ~op[2];
    end

    acc_opnd_cond u_cond (
        .op_i        (op_e),
        .sign_i      (operand[MAG_W]),
        .add_sign_o  (add_sign),
        .load_sign_o (load_sign)
    );

    acc_mag_addsub #(.MAG_W(MAG_W)) u_addsub (
        .acc_sign_i  (acc_sign),
        .acc_field_i (acc_field),
        .op_sign_i   (add_sign),
        .op_mag_i    (operand[MAG_W-1:0]),
        .res_sign_o  (res_sign),
        .res_field_o (res_field),
        .ovf_o       (res_ovf)
    );

    // Next accumulator value and overflow requests.
    always_comb begin
        acc_d   = acc;
        ovf_set = 1'b0;
        ovf_clr = 1'b0;
        case (op_e)
            OP_ADD, OP_SUB, OP_ADDM, OP_SUBM: begin
                acc_d   = {res_sign, res_field};
                ovf_set = start & res_ovf;
            end
            OP_LD, OP_LDN: acc_d = {load_sign, 2'b00, operand[MAG_W-1:0]};
            OP_RND: if (mq_hi) acc_d = {acc_sign, acc_field + FIELD_ONE};
            OP_TOV: ovf_clr = start;
            default: ;
        endcase
    end

    acc_ovf_flag u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovf_set),
        .clr_i  (ovf_clr),
        .flag_o (ovf)
    );

    // Register the accumulator, the test result and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            tov_flag <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                acc      <= acc_d;
                tov_flag <= (op_e == OP_TOV) ? ovf : 1'b0;
            end
        end
    end

    a_r9_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(acc) && $stable(ovf));
    a_r6_load_clears_guards: assert property (@(posedge clk) disable iff (!rst_n)
        start && (op_e == OP_LD || op_e == OP_LDN) |=>
        acc[FIELD_W-1:MAG_W] == 2'b00 && acc[MAG_W-1:0] == $past(operand[MAG_W-1:0]));
    a_r2_same_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        start && sum_op && (add_sign == acc_sign) |=> acc[ACC_W-1] == $past(acc_sign));
    a_r7_round_skip: assert property (@(posedge clk) disable iff (!rst_n)
        start && op_e == OP_RND && !mq_hi |=> $stable(acc));
    a_r8_test_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        start && op_e == OP_TOV |=> $stable(acc) && tov_flag == $past(ovf));
endmodule

// File: tb/acc_sm_adder_tb_top.sv
`timescale 1ns/1ps
module acc_sm_adder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  op;
    logic [35:0] operand;
    logic        mq_hi;
    logic [37:0] acc;
    logic        ovf, tov_flag, done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    acc_sm_adder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
        .mq_hi(mq_hi), .acc(acc), .ovf(ovf), .tov_flag(tov_flag), .done(done)
    );

    typedef struct packed {
        logic [35:0] init;
        logic [2:0]  op;
        logic [35:0] opnd;
        logic        mq;
        logic [37:0] exp_acc;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{36'd5,            3'd0, 36'd3,            1'b0, 38'd8,             1'b0},
        '{36'd5,            3'd1, 36'd3,            1'b0, 38'd2,             1'b0},
        '{36'd3,            3'd1, 36'd5,            1'b0, 38'h20_0000_0002,  1'b0},
        '{36'h8_0000_0007,  3'd0, 36'd7,            1'b0, 38'h20_0000_0000,  1'b0},
        '{36'h8_0000_0004,  3'd2, 36'h8_0000_0009,  1'b0, 38'd5,             1'b0},
        '{36'd4,            3'd3, 36'd9,            1'b0, 38'h20_0000_0005,  1'b0},
        '{36'h8_0000_0002,  3'd1, 36'h8_0000_0006,  1'b0, 38'd4,             1'b0},
        '{36'h8_0000_0002,  3'd0, 36'h8_0000_0006,  1'b0, 38'h20_0000_0008,  1'b0},
        '{36'h7_FFFF_FFFF,  3'd0, 36'd1,            1'b0, 38'h08_0000_0000,  1'b1},
        '{36'hF_FFFF_FFFF,  3'd0, 36'h8_0000_0001,  1'b0, 38'h28_0000_0000,  1'b1},
        '{36'd5,            3'd5, 36'd9,            1'b0, 38'h20_0000_0009,  1'b0},
        '{36'd5,            3'd4, 36'h8_0000_0009,  1'b0, 38'h20_0000_0009,  1'b0},
        '{36'd6,            3'd6, 36'd0,            1'b1, 38'd7,             1'b0},
        '{36'd6,            3'd6, 36'd0,            1'b0, 38'd6,             1'b0},
        '{36'h8_0000_0006,  3'd6, 36'd0,            1'b1, 38'h20_0000_0007,  1'b0},
        '{36'd5,            3'd2, 36'd3,            1'b0, 38'd8,             1'b0}
    };

    function automatic string op_req(logic [2:0] code);
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3: return "R2/R3/R5";
            3'd4, 3'd5:             return "R6";
            3'd6:                   return "R7";
            default:                return "R8";
        endcase
    endfunction

    // Two zero magnitudes compare equal whatever their signs.
    function automatic bit acc_eq(logic [37:0] a, logic [37:0] b);
        if (a[36:0] == 37'd0 && b[36:0] == 37'd0) return 1'b1;
        return a === b;
    endfunction

    task automatic chk_acc(string req, logic [37:0] got, logic [37:0] exp);
        checks++;
        if (!acc_eq(got, exp)) begin
            fails++;
            $display("FAIL %s acc: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic chk_bit(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // One start cycle; outputs are checked at the following falling edge.
    task automatic do_op(logic [2:0] code, logic [35:0] data, logic mq);
        @(negedge clk);
        start = 1'b1; op = code; operand = data; mq_hi = mq;
        @(negedge clk);
        start = 1'b0;
        chk_bit("R9", "done", done, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [37:0] held;
        rst_n = 1'b0; start = 1'b0; op = 3'd0; operand = '0; mq_hi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk_acc("R1", acc, 38'd0);
        chk_bit("R1", "ovf", ovf, 1'b0);
        chk_bit("R1", "tov_flag", tov_flag, 1'b0);
        chk_bit("R1", "done", done, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_op(3'd4, VECS[i].init, 1'b0);
            do_op(3'd7, 36'd0, 1'b0);
            do_op(VECS[i].op, VECS[i].opnd, VECS[i].mq);
            chk_acc(op_req(VECS[i].op), acc, VECS[i].exp_acc);
            chk_bit(op_req(VECS[i].op), "ovf", ovf, VECS[i].exp_ovf);
        end

        // R9: idle cycles hold the state and raise no done
        held = acc;
        @(negedge clk);
        @(negedge clk);
        chk_bit("R9", "idle done", done, 1'b0);
        chk_acc("R9", acc, held);

        // R4: overflow persists through further adds and a load
        do_op(3'd4, 36'h7_FFFF_FFFF, 1'b0);
        do_op(3'd7, 36'd0, 1'b0);
        do_op(3'd0, 36'd1, 1'b0);
        chk_bit("R2", "ovf set", ovf, 1'b1);
        do_op(3'd0, 36'd1, 1'b0);
        chk_acc("R4", acc, 38'h08_0000_0001);
        chk_bit("R4", "ovf kept", ovf, 1'b1);

        // R8: the test returns the flag and clears it, then returns zero
        do_op(3'd7, 36'd0, 1'b0);
        chk_bit("R8", "tov_flag", tov_flag, 1'b1);
        chk_bit("R8", "ovf cleared", ovf, 1'b0);
        chk_acc("R8", acc, 38'h08_0000_0001);
        do_op(3'd7, 36'd0, 1'b0);
        chk_bit("R8", "second tov_flag", tov_flag, 1'b0);

        // R3: P falls on the no-carry path without setting overflow
        do_op(3'd1, 36'd2, 1'b0);
        chk_acc("R3", acc, 38'h07_FFFF_FFFF);
        chk_bit("R3", "no-carry ovf", ovf, 1'b0);

        // R6: a load leaves a set overflow flag alone
        do_op(3'd0, 36'd1, 1'b0);
        chk_bit("R2", "ovf from P rise", ovf, 1'b1);
        do_op(3'd4, 36'd3, 1'b0);
        chk_acc("R6", acc, 38'd3);
        chk_bit("R6", "ovf after load", ovf, 1'b1);
        chk_bit("R8", "tov_flag zero after other op", tov_flag, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule